// File: doc/BRIEF.md
# Dithered Fractional Period Generator

This block stands in for a tunable ring oscillator and its power-of-two output divider, built entirely as synchronous logic. A fast strobe, `stage_tick`, counts as one stage delay. Each output cycle lasts a whole number of ticks, and that number is one of two neighbouring lengths. A phase accumulator chooses between them, so over any 32 cycles the mean period lands on a fractional stage count set by the low five bits of `stage_word`. The high three bits choose the coarse length. At the top coarse setting, the longer length is formed by running a 17-tick pass twice, which gives 34 ticks.

Each completed cycle raises `cyc_pulse` for one clock. A second counter passes through one cycle in every 2^k, where k comes from `div_code` and is held at 9 for any code above 9, and marks that cycle with `div_en`. Both strobes come from internal timing, so they have no valid/ready handshake: they are free-running events that cannot be held back, and the consumer must take each one in the clock where it appears. `stage_word` and `div_code` are plain control inputs. They are sampled only on the first tick of a cycle, so a cycle always runs to its full length.

Top module: `dither_period_gen`

## Requirements
- R1: With a fine field (`stage_word[4:0]`) of zero, every cycle lasts exactly 17 + 2·C ticks, where C is `stage_word[7:5]` (17 ticks for C=0, 29 for C=6).
- R2: For C below 7 and any 32 consecutive cycles with the same settings, F cycles last 19 + 2·C ticks and the rest last 17 + 2·C, where F is the fine field. The 32 cycles therefore total 32·(17+2C) + 2F ticks.
- R3: A fine field of 0 produces no long cycles. A fine field of 31 produces 31 long cycles in every 32.
- R4: For C = 7, each cycle lasts either 31 ticks or 34 ticks. The 34-tick cycle is a 17-tick pass run twice. F cycles out of every 32 are 34 ticks long.
- R5: `div_en` is high in exactly one out of every 2^D consecutive `cyc_pulse` strobes, where D is `div_code`, and only in a clock where `cyc_pulse` is also high. D=0 marks every pulse.
- R6: `div_code` values 10 to 15 divide by 512, the same as code 9.
- R7: `stage_word` and `div_code` are sampled on the first tick of each cycle. A change made partway through a cycle does not alter that cycle's length.
- R8: `cyc_pulse` is high for one clock, in the clock that follows the clock carrying the last tick of the cycle. Reset clears every counter and holds both outputs low.
- R9: A 5-bit accumulator spreads long cycles evenly. At each cycle start it adds F, and the cycle is long when the addition carries out. For example, F = 8 gives exactly one long cycle in every 4 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_tick | input | 1 | One-clock strobe; each tick is one stage delay |
| stage_word | input | 8 | [7:5] coarse length, [4:0] fine dither value |
| div_code | input | 4 | Divider exponent; values above 9 are treated as 9 |
| cyc_pulse | output | 1 | One-clock strobe at the end of every cycle |
| div_en | output | 1 | One-clock strobe on every 2^D-th cycle end |

## Verification
The assertions assume that `stage_tick` is a synchronous strobe, which may be high on every clock, and that the settings can change in any clock. The stimulus drives every input on the falling clock edge. Tick density is randomised between sparse and every-clock. One phase rewrites `stage_word` and `div_code` partway through cycles, so the settings are sampled mid-cycle as often as at cycle boundaries. A behavioural model in the bench counts ticks and accumulator carries independently of the RTL, and its expected strobes are compared with the outputs on every clock.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  // pass state of the stage counter
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } pass_e;

endpackage

// File: rtl/dpg_dither.sv
module dpg_dither #(
  parameter int FINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FINE_W-1:0] fine_in,
  output logic              long_o
);

  logic [FINE_W-1:0] acc_q;
  logic [FINE_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, fine_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      long_o <= 1'b0;
    end else if (load) begin
      acc_q  <= sum[FINE_W-1:0];
      long_o <= sum[FINE_W];
    end
  end

  // R3
  zero_fine_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && fine_in == '0) |=> !long_o);

  // R3
  full_fine_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && fine_in == '1 && acc_q != '0) |=> long_o);

endmodule

// File: rtl/dpg_stage_cnt.sv
module dpg_stage_cnt
  import dpg_pkg::*;
#(
  parameter int COARSE_W   = 3,
  parameter int BASE_LEN   = 17,
  parameter bit DOUBLE_TOP = 1'b1,
  parameter int CNT_W      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [COARSE_W-1:0] coarse_in,
  input  logic                long_i,
  output logic                load_o,
  output logic                cyc_end_o
);

  pass_e               ph_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [COARSE_W-1:0] coarse_q;
  logic [CNT_W-1:0]    base;
  logic                dbl;
  logic                last_pass;
  logic                pass_end;

  generate
    if (DOUBLE_TOP) begin : g_dbl
      assign dbl = (coarse_q == {COARSE_W{1'b1}}) && long_i;
    end else begin : g_nodbl
      assign dbl = 1'b0;
    end
  endgenerate

  always_comb begin
    if (dbl)
      base = CNT_W'(BASE_LEN);
    else
      base = CNT_W'(BASE_LEN) + CNT_W'({coarse_q, 1'b0}) + (long_i ? CNT_W'(2) : CNT_W'(0));
  end

  assign last_pass = !dbl || (ph_q == PH_SECOND);
  assign pass_end  = tick && (ph_q != PH_IDLE) && (cnt_q == base - CNT_W'(1));
  assign load_o    = tick && (ph_q == PH_IDLE);
  assign cyc_end_o = pass_end && last_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      coarse_q <= '0;
    end else if (load_o) begin
      ph_q     <= PH_FIRST;
      cnt_q    <= CNT_W'(1);
      coarse_q <= coarse_in;
    end else if (pass_end) begin
      cnt_q <= '0;
      ph_q  <= last_pass ? PH_IDLE : PH_SECOND;
    end else if (tick && ph_q != PH_IDLE) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R4
  second_pass_doubled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SECOND) |-> dbl);

  // R1
  cnt_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (cnt_q < base));

  // R7
  coarse_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |=> $stable(coarse_q));

endmodule

// File: rtl/dpg_pow2_div.sv
module dpg_pow2_div #(
  parameter int DIV_W   = 4,
  parameter int DIV_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] code_in,
  input  logic             step,
  output logic             en_o
);

  localparam int DCNT_W = DIV_MAX + 1;

  logic [DIV_W-1:0]  exp_q;
  logic [DIV_W-1:0]  exp_sat;
  logic [DCNT_W-1:0] cnt_q;
  logic [DCNT_W-1:0] lim_m1;
  logic              wrap;

  assign exp_sat = (code_in > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : code_in;
  assign lim_m1  = (DCNT_W'(1) << exp_q) - DCNT_W'(1);
  assign wrap    = (cnt_q >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else begin
      if (load)
        exp_q <= exp_sat;
      if (step) begin
        cnt_q <= wrap ? '0 : cnt_q + DCNT_W'(1);
        en_o  <= wrap;
      end else begin
        en_o  <= 1'b0;
      end
    end
  end

  // R6
  exp_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q <= DIV_W'(DIV_MAX));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q <= $past(lim_m1)));

endmodule

// File: rtl/dither_period_gen.sv
module dither_period_gen #(
  parameter int STAGE_W    = 8,
  parameter int FINE_W     = 5,
  parameter int DIV_W      = 4,
  parameter int DIV_MAX    = 9,
  parameter int BASE_LEN   = 17,
  parameter bit DOUBLE_TOP = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stage_tick,
  input  logic [STAGE_W-1:0] stage_word,
  input  logic [DIV_W-1:0]   div_code,
  output logic               cyc_pulse,
  output logic               div_en
);

  localparam int COARSE_W = STAGE_W - FINE_W;
  localparam int MAX_LEN  = BASE_LEN + 2 * ((1 << COARSE_W) - 1) + 2;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic load;
  logic cyc_end;
  logic long_cyc;

  dpg_dither #(.FINE_W(FINE_W)) u_dither (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .fine_in (stage_word[FINE_W-1:0]),
    .long_o  (long_cyc)
  );

  dpg_stage_cnt #(
    .COARSE_W   (COARSE_W),
    .BASE_LEN   (BASE_LEN),
    .DOUBLE_TOP (DOUBLE_TOP),
    .CNT_W      (CNT_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (stage_tick),
    .coarse_in (stage_word[STAGE_W-1:FINE_W]),
    .long_i    (long_cyc),
    .load_o    (load),
    .cyc_end_o (cyc_end)
  );

  dpg_pow2_div #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .code_in (div_code),
    .step    (cyc_end),
    .en_o    (div_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_pulse <= 1'b0;
    else        cyc_pulse <= cyc_end;
  end

  // R5
  div_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |-> cyc_pulse);

  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |-> $past(stage_tick));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |=> !cyc_pulse);

endmodule

// File: tb/dither_period_gen_tb.sv
module dither_period_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stage_tick = 1'b0;
  logic [7:0] stage_word = 8'h00;
  logic [3:0] div_code = 4'd0;
  logic       cyc_pulse;
  logic       div_en;

  int    n_chk = 0;
  int    n_fail = 0;
  int    tick_pct = 60;
  bit    tick_on = 1'b0;
  string cur_req = "R8";

  // model state
  int m_cnt = 0, m_len = 0, m_acc = 0, m_dcnt = 0, m_dlim = 1;
  int tick_total = 0;
  bit exp_cyc = 1'b0, exp_div = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_period_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_tick (stage_tick),
    .stage_word (stage_word),
    .div_code   (div_code),
    .cyc_pulse  (cyc_pulse),
    .div_en     (div_en)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk)
    stage_tick <= tick_on && ($urandom_range(0, 99) < tick_pct);

  // behavioural reference, compared on every clock
  always @(posedge clk) begin
    exp_cyc = 1'b0;
    exp_div = 1'b0;
    if (!rst_n) begin
      m_cnt = 0; m_len = 0; m_acc = 0; m_dcnt = 0; m_dlim = 1;
    end else if (stage_tick) begin
      tick_total++;
      if (m_cnt == 0) begin
        int c, f, d;
        bit lng;
        c = stage_word[7:5];
        f = stage_word[4:0];
        m_acc = m_acc + f;
        lng = (m_acc >= 32);
        m_acc = m_acc % 32;
        if (c == 7) m_len = lng ? 34 : 31;
        else        m_len = 17 + 2*c + (lng ? 2 : 0);
        d = (div_code > 9) ? 9 : div_code;
        m_dlim = 1 << d;
        m_cnt = 1;
      end else if (m_cnt == m_len - 1) begin
        m_cnt = 0;
        exp_cyc = 1'b1;
        if (m_dcnt + 1 >= m_dlim) begin
          m_dcnt = 0;
          exp_div = 1'b1;
        end else begin
          m_dcnt++;
        end
      end else begin
        m_cnt++;
      end
    end
    #1;
    chk(cyc_pulse === exp_cyc, cur_req, "cyc_pulse vs model", cyc_pulse, exp_cyc);
    chk(div_en === exp_div, cur_req, "div_en vs model", div_en, exp_div);
  end

  task automatic wait_pulse();
    do begin @(posedge clk); #2; end while (!cyc_pulse);
  endtask

  task automatic wait_div();
    do begin @(posedge clk); #2; end while (!div_en);
  endtask

  task automatic run_frame(input logic [7:0] w, input string tag);
    int t0, prev, d, bad, c, f, expt;
    c = w[7:5];
    f = w[4:0];
    expt = (c == 7) ? (31*(32-f) + 34*f) : (32*(17+2*c) + 2*f);
    cur_req = tag;
    @(negedge clk);
    stage_word = w;
    wait_pulse();
    wait_pulse();
    t0 = tick_total;
    prev = t0;
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      wait_pulse();
      d = tick_total - prev;
      prev = tick_total;
      if (c == 7 && d != 31 && d != 34) bad++;
      if (f == 0 && d != 17 + 2*c && c != 7) bad++;
    end
    chk(tick_total - t0 == expt, tag, "ticks in 32 cycles", tick_total - t0, expt);
    chk(bad == 0, tag, "cycles of wrong length", bad, 0);
  endtask

  task automatic run_div(input logic [3:0] code, input int expn, input string tag);
    int n;
    cur_req = tag;
    @(negedge clk);
    div_code = code;
    wait_div();
    wait_div();
    n = 0;
    do begin wait_pulse(); n++; end while (!div_en);
    chk(n == expn, tag, "cycles per divided strobe", n, expn);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk(cyc_pulse === 1'b0, "R8", "cyc_pulse in reset", cyc_pulse, 0);
    chk(div_en === 1'b0, "R8", "div_en in reset", div_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cyc_pulse === 1'b0, "R8", "cyc_pulse idle after reset", cyc_pulse, 0);
    tick_on = 1'b1;

    // R1 nominal lengths
    run_frame(8'h00, "R1");
    run_frame(8'h60, "R1");
    run_frame(8'hC0, "R1");
    // R2 fractional frames
    run_frame(8'h61, "R2");
    run_frame(8'h67, "R2");
    run_frame(8'h70, "R2");
    run_frame(8'h4A, "R2");
    // R3 extremes of the fine field
    run_frame(8'h7F, "R3");
    run_frame(8'h20, "R3");
    // R4 top coarse setting
    run_frame(8'hE0, "R4");
    run_frame(8'hE5, "R4");
    run_frame(8'hFF, "R4");

    // R9 even spreading: F=8 -> one long cycle in each group of 4
    begin
      int prev, t;
      cur_req = "R9";
      @(negedge clk);
      stage_word = 8'h08;
      wait_pulse();
      wait_pulse();
      prev = tick_total;
      for (int g = 0; g < 8; g++) begin
        for (int k = 0; k < 4; k++) wait_pulse();
        t = tick_total - prev;
        prev = tick_total;
        chk(t == 70, "R9", "ticks in 4-cycle group", t, 70);
      end
    end

    // R7 settings changed mid-cycle, checked by the per-clock model
    cur_req = "R7";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      stage_word = 8'($urandom_range(0, 255));
      div_code   = 4'($urandom_range(0, 3));
      tick_pct   = $urandom_range(20, 100);
      repeat ($urandom_range(1, 15)) @(negedge clk);
    end

    // R5 / R6 divider with dense ticks and short cycles
    tick_pct = 100;
    @(negedge clk);
    stage_word = 8'h00;
    run_div(4'd0, 1, "R5");
    run_div(4'd3, 8, "R5");
    run_div(4'd9, 512, "R5");
    run_div(4'd15, 512, "R6");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule